// File: doc/BRIEF.md
# Banked Seven-Point Stencil Engine

The engine adds up each point of an 8x8x8 cube and its six axis neighbours. The cube is stored linearly, with `addr = x + 8*y + 64*z`. The neighbours sit at address displacements of ±1, ±8 and ±64. The cube is spread over seven single-port memory banks by cyclic interleaving. A command gives a first centre address and a count. The engine then walks that run of consecutive centres and delivers one sum per clock.

With only seven banks, the seven operands of one centre cannot all be read in the same cycle. The engine therefore staggers its reads over several iterations. In every steady-state cycle it fetches:

- the -64 operand of iteration n,
- the -8 operand of iteration n+1,
- the centre, +1 and -1 operands of iteration n+2,
- the +8 operand of iteration n+3,
- the +64 operand of iteration n+4.

These seven addresses always land in seven different banks. Operands that arrive early wait in short delay lines until the last operand of their centre arrives. The seven values are then added and registered.

The caller must keep every operand inside the cube. This means `base_addr >= 64` and `base_addr + length + 63 <= 511`. Row and plane edges are not treated specially.

Top module: `stencil7_engine`

## Requirements
- R1: After reset, `busy`, `res_valid` and every bit of `bank_rd_en` are low.
- R2: Element `a` lives in bank `a mod 7` at slot `a div 7`. A read sets `bank_rd_en[b]` with the slot on `bank_addr[b]`, and the data is expected on `bank_rdata[b]` one cycle later.
- R3: No bank is asked for more than one read in any cycle.
- R4: `res_data` equals the sum of the centre element and the elements at -64, -8, -1, +1, +8 and +64 from it. The output is 3 bits wider than the data, so the sum never wraps.
- R5: A run with length L raises `res_valid` for exactly L cycles. The results come in consecutive cycles, for centres `base_addr`, `base_addr+1`, …, in that order.
- R6: The result for centre `base_addr+n` appears right after the 6+n-th rising edge that follows the edge accepting the command.
- R7: With L at least 4, all seven banks are read together in exactly L-4 cycles of the run.
- R8: A `start` raised while `busy` is high is ignored, and the running job is unaffected.
- R9: A `start` with length 0 is ignored: no busy, no reads, no results.
- R10: `busy` stays high for exactly L+6 cycles after an accepted command, covering the prologue and the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted when idle and `length` is non-zero |
| base_addr | input | AW | First centre address |
| length | input | LW | Number of centres |
| busy | output | 1 | Run in progress, including the drain |
| bank_rd_en | output | 7 | Read request per bank |
| bank_addr | output | 7 x SLOT_W | Slot address per bank |
| bank_rdata | input | 7 x DW | Read data per bank, one cycle after the request |
| res_valid | output | 1 | Result strobe |
| res_data | output | DW+3 | Seven-point sum |

## Verification
Each result is due a fixed number of cycles after the command is accepted: result n follows edge 6+n after the accepting edge. Accordingly, the bench records the edge index of every `res_valid` and compares it with that count. Sums are checked against a software sum over a randomly filled cube. `busy` length and the number of fully parallel read cycles are counted per run and compared with L+6 and L-4.

// File: rtl/stencil7_pkg.sv
package stencil7_pkg;
  localparam int NBANKS  = 7;
  localparam int NOPS    = 7;
  localparam int ROW     = 8;
  localparam int PLANE   = 64;
  localparam int MAXLEAD = 4;

  // operand order: centre, +1, -1, +row, -row, +plane, -plane
  function automatic int op_disp(input int k);
    case (k)
      0:       return 0;
      1:       return 1;
      2:       return -1;
      3:       return ROW;
      4:       return -ROW;
      5:       return PLANE;
      default: return -PLANE;
    endcase
  endfunction

  // how many iterations ahead of the closing read this operand is fetched
  function automatic int op_lead(input int k);
    case (k)
      0, 1, 2: return 2;
      3:       return 3;
      4:       return 1;
      5:       return MAXLEAD;
      default: return 0;
    endcase
  endfunction

  function automatic int closing_op();
    for (int k = 0; k < NOPS; k++)
      if (op_lead(k) == 0) return k;
    return 0;
  endfunction

  function automatic int bank_of(input int a);
    return a % NBANKS;
  endfunction

  function automatic int slot_of(input int a);
    return a / NBANKS;
  endfunction
endpackage

// File: rtl/stencil7_seq.sv
module stencil7_seq #(
  parameter int AW = 9,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] length,
  output logic          busy,
  output logic [LW:0]   step,
  output logic [AW-1:0] base_q,
  output logic [LW-1:0] len_q
);
  import stencil7_pkg::*;
  localparam int TAIL = MAXLEAD + 1;

  logic accept, last_step;
  assign accept    = start && !busy && (length != '0);
  assign last_step = (step == ({1'b0, len_q} + (LW+1)'(TAIL)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= '0;
      base_q <= '0;
      len_q  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      step   <= '0;
      base_q <= base_addr;
      len_q  <= length;
    end else if (busy) begin
      if (last_step) busy <= 1'b0;
      else           step <= step + 1'b1;
    end
  end
endmodule

// File: rtl/stencil7_xbar.sv
module stencil7_xbar #(
  parameter int AW     = 9,
  parameter int LW     = 10,
  parameter int DW     = 16,
  parameter int SLOT_W = 7
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          busy,
  input  logic [LW:0]                                   step,
  input  logic [AW-1:0]                                 base_q,
  input  logic [LW-1:0]                                 len_q,
  output logic [stencil7_pkg::NBANKS-1:0]               bank_rd_en,
  output logic [stencil7_pkg::NBANKS-1:0][SLOT_W-1:0]   bank_addr,
  input  logic [stencil7_pkg::NBANKS-1:0][DW-1:0]       bank_rdata,
  output logic [stencil7_pkg::NOPS-1:0][DW-1:0]         op_data,
  output logic [stencil7_pkg::NOPS-1:0]                 op_live,
  output logic                                          bank_conflict
);
  import stencil7_pkg::*;
  localparam int BW = $clog2(NBANKS);

  logic [NOPS-1:0]             op_en;
  logic [NOPS-1:0][BW-1:0]     op_bank;
  logic [NOPS-1:0][SLOT_W-1:0] op_slot;
  logic [NOPS-1:0][BW-1:0]     sel_q;

  always_comb begin
    int iter;
    int addr;
    for (int k = 0; k < NOPS; k++) begin
      iter = int'(step) - MAXLEAD + op_lead(k);
      addr = int'(base_q) + iter + op_disp(k);
      op_en[k] = busy && (iter >= 0) && (iter < int'(len_q));
      if (op_en[k]) begin
        op_bank[k] = BW'(bank_of(addr));
        op_slot[k] = SLOT_W'(slot_of(addr));
      end else begin
        op_bank[k] = '0;
        op_slot[k] = '0;
      end
    end
  end

  always_comb begin
    bank_rd_en    = '0;
    bank_addr     = '0;
    bank_conflict = 1'b0;
    for (int k = 0; k < NOPS; k++) begin
      if (op_en[k]) begin
        if (bank_rd_en[op_bank[k]]) bank_conflict = 1'b1;
        bank_rd_en[op_bank[k]] = 1'b1;
        bank_addr[op_bank[k]]  = op_slot[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      op_live <= '0;
    end else begin
      sel_q   <= op_bank;
      op_live <= op_en;
    end
  end

  always_comb
    for (int k = 0; k < NOPS; k++)
      op_data[k] = bank_rdata[sel_q[k]];
endmodule

// File: rtl/stencil7_align.sv
module stencil7_align #(
  parameter int DW = 16,
  parameter int SW = DW + 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [stencil7_pkg::NOPS-1:0][DW-1:0] op_data,
  input  logic [stencil7_pkg::NOPS-1:0]         op_live,
  output logic                                  res_valid,
  output logic [SW-1:0]                         res_data
);
  import stencil7_pkg::*;
  localparam int CLOSE = closing_op();

  logic [NOPS-1:0][DW-1:0] aligned;
  logic [SW-1:0]           total;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    localparam int DEPTH = op_lead(k);
    if (DEPTH == 0) begin : g_direct
      assign aligned[k] = op_data[k];
    end else begin : g_delay
      logic [DEPTH-1:0][DW-1:0] line;
      always_ff @(posedge clk) begin
        line[0] <= op_data[k];
        for (int j = 1; j < DEPTH; j++) line[j] <= line[j-1];
      end
      assign aligned[k] = line[DEPTH-1];
    end
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < NOPS; k++) total = total + SW'(aligned[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= op_live[CLOSE];
      if (op_live[CLOSE]) res_data <= total;
    end
  end
endmodule

// File: rtl/stencil7_engine.sv
module stencil7_engine
  import stencil7_pkg::*;
#(
  parameter int AW     = 9,
  parameter int LW     = 10,
  parameter int DW     = 16,
  parameter int SW     = DW + 3,
  parameter int SLOT_W = $clog2((2**AW + NBANKS - 1) / NBANKS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [AW-1:0]                  base_addr,
  input  logic [LW-1:0]                  length,
  output logic                           busy,
  output logic [NBANKS-1:0]              bank_rd_en,
  output logic [NBANKS-1:0][SLOT_W-1:0]  bank_addr,
  input  logic [NBANKS-1:0][DW-1:0]      bank_rdata,
  output logic                           res_valid,
  output logic [SW-1:0]                  res_data
);
  logic [LW:0]             step;
  logic [AW-1:0]           base_q;
  logic [LW-1:0]           len_q;
  logic [NOPS-1:0][DW-1:0] op_data;
  logic [NOPS-1:0]         op_live;
  logic                    bank_conflict;

  stencil7_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .length(length), .busy(busy), .step(step), .base_q(base_q), .len_q(len_q)
  );

  stencil7_xbar #(.AW(AW), .LW(LW), .DW(DW), .SLOT_W(SLOT_W)) u_xbar (
    .clk(clk), .rst_n(rst_n), .busy(busy), .step(step), .base_q(base_q),
    .len_q(len_q), .bank_rd_en(bank_rd_en), .bank_addr(bank_addr),
    .bank_rdata(bank_rdata), .op_data(op_data), .op_live(op_live),
    .bank_conflict(bank_conflict)
  );

  stencil7_align #(.DW(DW), .SW(SW)) u_align (
    .clk(clk), .rst_n(rst_n), .op_data(op_data), .op_live(op_live),
    .res_valid(res_valid), .res_data(res_data)
  );
endmodule

// File: rtl/stencil7_chk.sv
module stencil7_chk #(
  parameter int LW = 10,
  parameter int NB = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] length,
  input logic          busy,
  input logic [NB-1:0] bank_rd_en,
  input logic          bank_conflict,
  input logic          res_valid
);
  logic [LW-1:0] len_cap;
  logic [LW:0]   seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_cap <= '0;
      seen    <= '0;
    end else if (start && !busy && length != '0) begin
      len_cap <= length;
      seen    <= '0;
    end else if (res_valid) begin
      seen <= seen + 1'b1;
    end
  end

  // R3
  single_read_per_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_conflict);

  // R5
  result_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> seen == {1'b0, len_cap});

  // R9
  zero_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && length == '0) |=> !busy);

  // R9
  run_needs_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && $past(length) != '0));

  // R10
  result_inside_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));

  // R1
  idle_no_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bank_rd_en == '0);
endmodule

bind stencil7_engine stencil7_chk #(.LW(LW), .NB(stencil7_pkg::NBANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .length(length), .busy(busy),
  .bank_rd_en(bank_rd_en), .bank_conflict(bank_conflict), .res_valid(res_valid)
);

// File: tb/stencil7_engine_test.sv
module stencil7_engine_test;
  localparam int DW = 16, AW = 9, LW = 10, NB = 7, SW = DW + 3;
  localparam int SLOT_W = $clog2((2**AW + NB - 1) / NB);
  localparam int CUBE = 512;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [LW-1:0] length = '0;
  logic busy, res_valid;
  logic [NB-1:0] bank_rd_en;
  logic [NB-1:0][SLOT_W-1:0] bank_addr;
  logic [NB-1:0][DW-1:0] bank_rdata;
  logic [SW-1:0] res_data;

  stencil7_engine #(.AW(AW), .LW(LW), .DW(DW)) uut (.*);

  always #4 clk = ~clk;

  logic [DW-1:0] cube [CUBE];
  int cyc = 0, total = 0, fails = 0;
  int n_res, busy_cnt, full_cnt, rd_cnt;
  int res_v [CUBE];
  int res_c [CUBE];
  bit mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // bank model: cyclic interleave, one-cycle read latency
  always_ff @(posedge clk)
    for (int b = 0; b < NB; b++)
      if (bank_rd_en[b])
        bank_rdata[b] <= (int'(bank_addr[b]) * NB + b < CUBE) ?
                         cube[int'(bank_addr[b]) * NB + b] : '0;

  always @(negedge clk) if (mon_on) begin
    if (res_valid) begin
      if (n_res < CUBE) begin
        res_v[n_res] = int'(res_data);
        res_c[n_res] = cyc;
      end
      n_res++;
    end
    if (busy) busy_cnt++;
    if (&bank_rd_en) full_cnt++;
    if (|bank_rd_en) rd_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_sum(input int c);
    return int'(cube[c]) + int'(cube[c+1]) + int'(cube[c-1]) + int'(cube[c+8]) +
           int'(cube[c-8]) + int'(cube[c+64]) + int'(cube[c-64]);
  endfunction

  task automatic clear_mon();
    n_res = 0; busy_cnt = 0; full_cnt = 0; rd_cnt = 0; mon_on = 1'b1;
  endtask

  // one run; optionally pulses a second start mid-run (R8)
  task automatic run_job(input int base, input int len, input bit intrude);
    int p, bad_t, bad_v;
    clear_mon();
    @(negedge clk);
    start = 1'b1; base_addr = AW'(base); length = LW'(len);
    @(negedge clk);
    start = 1'b0;
    p = cyc;
    if (intrude) begin
      repeat (3) @(negedge clk);
      start = 1'b1; base_addr = AW'(base + 37); length = LW'(len + 9);
      @(negedge clk);
      start = 1'b0; base_addr = '0; length = '0;
    end
    repeat (len + 14) @(negedge clk);
    check(n_res == len, "R5", "result count", n_res, len);
    bad_t = 0; bad_v = 0;
    for (int n = 0; n < len && n < n_res; n++) begin
      if (res_c[n] != p + 6 + n) bad_t++;
      // R4 R2 R3: each sum matches the software sum of the seven neighbours
      check(res_v[n] == ref_sum(base + n), "R4", "sum", res_v[n], ref_sum(base + n));
    end
    check(bad_t == 0, "R6", "results off schedule", bad_t, 0);
    check(busy_cnt == len + 6, "R10", "busy cycles", busy_cnt, len + 6);
    check(full_cnt == ((len > 4) ? len - 4 : 0), "R7", "seven-bank cycles",
          full_cnt, (len > 4) ? len - 4 : 0);
    mon_on = 1'b0;
  endtask

  task automatic zero_job();
    clear_mon();
    @(negedge clk);
    start = 1'b1; base_addr = AW'(100); length = '0;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    check(busy_cnt == 0, "R9", "busy after zero length", busy_cnt, 0);
    check(n_res == 0, "R9", "results after zero length", n_res, 0);
    check(rd_cnt == 0, "R9", "reads after zero length", rd_cnt, 0);
    mon_on = 1'b0;
  endtask

  task automatic reset_check();
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);
    check(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);
    check(bank_rd_en == '0, "R1", "bank_rd_en", int'(bank_rd_en), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int a = 0; a < CUBE; a++) cube[a] = DW'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_check();
    run_job(64, 384, 1'b0);
    run_job(200, 1, 1'b0);
    run_job(100, 3, 1'b0);
    run_job(300, 20, 1'b1);
    zero_job();
    run_job(250, 5, 1'b0);
    for (int a = 0; a < CUBE; a++) cube[a] = '1;
    run_job(150, 30, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule